// File: doc/BRIEF.md
# Odd-Forced Modular Multiplier

This block returns the low N bits of the product of two unsigned N-bit operands, that is A times B modulo 2^N. It never multiplies an even operand. An even operand is raised by one so that it is odd, and the two odd values are multiplied modulo 2^N. A correction term is then subtracted from that product. The term is chosen by the least significant bits of the two original operands and formed by gating the operands.

The odd-by-odd multiply sits in its own submodule. A cheaper odd-only core, for example one that maps odd residues onto a pair of small adders, can replace it without touching the forcing or correction logic. By default the core is a plain behavioural multiply. The result is captured in a single register stage. A valid strobe travels alongside the data and arrives one clock after the operands.

Top module: `odd_force_mult`

## Requirements
- R1: Each operand is forced to an odd value before the multiply. An even operand X becomes X+1, and an odd operand passes through unchanged. The even operand 2^N-2 becomes 2^N-1 with no wrap to zero.
- R2: When `in_valid` is high at a rising clock edge, `product` shows (A*B) mod 2^N from that edge onward.
- R3: When both operand LSBs are 0, the correction subtracted from the odd product is A+B+1. Products of two even operands are exact.
- R4: When the A LSB is 0 and the B LSB is 1, the correction is B. Products of an even A and an odd B are exact.
- R5: When the A LSB is 1 and the B LSB is 0, the correction is A. Products of an odd A and an even B are exact.
- R6: When both LSBs are 1, no correction is applied, and the product of the two odd operands is returned as it is.
- R7: Every sum, difference and product discards the carry out of bit N-1. For example, (2^N-1)*(2^N-1) gives 1.
- R8: `out_valid` is high in the cycle after `in_valid` was high at an edge, and low after an edge at which `in_valid` was low.
- R9: While `rst_n` is low, `product` is 0 and `out_valid` is 0.
- R10: An edge at which `in_valid` is low leaves `product` unchanged, whatever the operand inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| a_in | input | WIDTH | Unsigned operand A |
| b_in | input | WIDTH | Unsigned operand B |
| out_valid | output | 1 | Product register holds a fresh result |
| product | output | WIDTH | (A*B) mod 2^WIDTH, registered |

## Verification
The hardest case to reach from the ports is an even operand at the very top of the range, 2^N-2. Forcing it must give 2^N-1 with no wrap to zero, and the correction sum must then overflow and be truncated. That overflow is correct only when every stage discards its carry in the same way. The bench reaches this case by sweeping every operand pair at N=4. It then drives 2^N-2 and 2^N-1 directly at N=8, against all four LSB classes, before a random run.

// File: rtl/odd_force_mult_pkg.sv
package odd_force_mult_pkg;

    // Class of the operand LSB pair {a0, b0}; the correction term depends on it.
    typedef enum logic [1:0] {
        LSB_EVEN_EVEN = 2'b00,
        LSB_EVEN_ODD  = 2'b01,
        LSB_ODD_EVEN  = 2'b10,
        LSB_ODD_ODD   = 2'b11
    } lsb_pair_e;

    // A forcing increment is needed exactly when the operand is even.
    function automatic logic needs_bump(input logic lsb);
        return ~lsb;
    endfunction

endpackage

// File: rtl/operand_forcer.sv
module operand_forcer #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] odd_val,
    output logic             bumped
);
    import odd_force_mult_pkg::*;

    // Adding one to an even value only flips bit 0, so no carry can travel.
    always_comb begin
        bumped  = needs_bump(raw[0]);
        odd_val = {raw[WIDTH-1:1], 1'b1};
    end

endmodule

// File: rtl/odd_core_mult.sv
module odd_core_mult #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_odd,
    input  logic [WIDTH-1:0] y_odd,
    output logic [WIDTH-1:0] p_odd
);
    // Behavioural core; a residue-indexed odd-only core may replace it.
    always_comb begin
        p_odd = x_odd * y_odd;
    end

endmodule

// File: rtl/correction_unit.sv
module correction_unit #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_raw,
    input  logic [WIDTH-1:0] b_raw,
    input  logic             a_bumped,
    input  logic             b_bumped,
    output logic [WIDTH-1:0] corr
);
    logic [WIDTH-1:0] gate_a;
    logic [WIDTH-1:0] gate_b;
    logic             both;

    // A enters the term when B was bumped; B enters when A was bumped.
    for (genvar i = 0; i < WIDTH; i++) begin : g_gate
        assign gate_a[i] = a_raw[i] & b_bumped;
        assign gate_b[i] = b_raw[i] & a_bumped;
    end

    assign both = a_bumped & b_bumped;

    always_comb begin
        corr = gate_a + gate_b + {{(WIDTH-1){1'b0}}, both};
    end

endmodule

// File: rtl/odd_force_mult.sv
module odd_force_mult #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] product
);
    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] prod;
    } state_t;

    state_t state_d, state_q;

    logic [WIDTH-1:0] a_odd, b_odd, p_odd, corr;
    logic             a_bumped, b_bumped;

    operand_forcer #(.WIDTH(WIDTH)) i_force_a (
        .raw(a_in), .odd_val(a_odd), .bumped(a_bumped)
    );

    operand_forcer #(.WIDTH(WIDTH)) i_force_b (
        .raw(b_in), .odd_val(b_odd), .bumped(b_bumped)
    );

    odd_core_mult #(.WIDTH(WIDTH)) i_core (
        .x_odd(a_odd), .y_odd(b_odd), .p_odd(p_odd)
    );

    correction_unit #(.WIDTH(WIDTH)) i_corr (
        .a_raw(a_in), .b_raw(b_in),
        .a_bumped(a_bumped), .b_bumped(b_bumped),
        .corr(corr)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.prod = p_odd - corr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign product   = state_q.prod;

endmodule

// File: rtl/odd_force_mult_chk.sv
module odd_force_mult_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             out_valid,
    input logic [WIDTH-1:0] product,
    input logic [WIDTH-1:0] a_odd,
    input logic [WIDTH-1:0] b_odd
);
    // R1: forced operands are odd and differ from the raw ones by the bump only
    a_r1_forced_a: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (a_odd[0] && (a_in[0] ? (a_odd == a_in) : (a_odd == a_in + 1'b1))));
    a_r1_forced_b: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (b_odd[0] && (b_in[0] ? (b_odd == b_in) : (b_odd == b_in + 1'b1))));

    // R2: registered result matches the truncated product of the sampled operands
    a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (product == WIDTH'($past(a_in) * $past(b_in))));

    // R8: strobe timing
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10: idle edges keep the product
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));

endmodule

bind odd_force_mult odd_force_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_in(a_in), .b_in(b_in), .out_valid(out_valid), .product(product),
    .a_odd(a_odd), .b_odd(b_odd)
);

// File: tb/test_odd_force_mult.sv
module test_odd_force_mult;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // N = 8 instance
    logic       v8 = 1'b0;
    logic [7:0] a8 = '0, b8 = '0;
    logic       ov8;
    logic [7:0] p8;

    odd_force_mult #(.WIDTH(8)) i_odd_force_mult (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .a_in(a8), .b_in(b8),
        .out_valid(ov8), .product(p8)
    );

    // N = 4 instance for the exhaustive sweep
    logic       v4 = 1'b0;
    logic [3:0] a4 = '0, b4 = '0;
    logic       ov4;
    logic [3:0] p4;

    odd_force_mult #(.WIDTH(4)) i_odd_force_mult_w4 (
        .clk(clk), .rst_n(rst_n), .in_valid(v4), .a_in(a4), .b_in(b4),
        .out_valid(ov4), .product(p4)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string class_tag(input int a, input int b);
        case ({a[0], b[0]})
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    // Drive one pair on N=8 and check the registered product one edge later.
    task automatic mul8(input int a, input int b, input string req);
        int exp;
        @(negedge clk);
        a8 = 8'(a); b8 = 8'(b); v8 = 1'b1;
        @(negedge clk);
        v8 = 1'b0;
        exp = (a * b) % 256;
        check(p8 == 8'(exp), req, int'(p8), exp);
        check(ov8 == 1'b1, "R8", int'(ov8), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(p8 == 8'd0, "R9", int'(p8), 0);
        check(ov8 == 1'b0, "R9", int'(ov8), 0);
        check(p4 == 4'd0 && ov4 == 1'b0, "R9", int'(p4), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_sweep4();
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                int exp;
                @(negedge clk);
                a4 = 4'(a); b4 = 4'(b); v4 = 1'b1;
                @(negedge clk);
                v4 = 1'b0;
                exp = (a * b) % 16;
                check(p4 == 4'(exp), {"R2 ", class_tag(a, b), " R7"}, int'(p4), exp);
            end
        end
    endtask

    task automatic t_classes8();
        mul8(6, 10, "R3");
        mul8(0, 0, "R3");
        mul8(200, 77, "R4");
        mul8(77, 200, "R5");
        mul8(13, 57, "R6");
    endtask

    task automatic t_wrap8();
        mul8(255, 255, "R7");
        mul8(128, 2, "R7");
        mul8(254, 254, "R1 R3");
        mul8(254, 255, "R1 R4");
        mul8(255, 254, "R1 R5");
        mul8(254, 1, "R1");
    endtask

    task automatic t_random8();
        for (int k = 0; k < 300; k++) begin
            int a, b;
            a = int'($urandom_range(255));
            b = int'($urandom_range(255));
            mul8(a, b, "R2");
        end
    endtask

    task automatic t_valid8();
        @(negedge clk);
        a8 = 8'd3; b8 = 8'd5; v8 = 1'b1;
        check(ov8 == 1'b0, "R8", int'(ov8), 0);
        @(negedge clk);
        v8 = 1'b0;
        check(ov8 == 1'b1, "R8", int'(ov8), 1);
        @(negedge clk);
        check(ov8 == 1'b0, "R8", int'(ov8), 0);
    endtask

    task automatic t_hold8();
        mul8(9, 11, "R2");
        @(negedge clk);
        a8 = 8'd100; b8 = 8'd42;
        @(negedge clk);
        check(p8 == 8'd99, "R10", int'(p8), 99);
        a8 = 8'd254; b8 = 8'd6;
        @(negedge clk);
        check(p8 == 8'd99, "R10", int'(p8), 99);
        check(ov8 == 1'b0, "R10", int'(ov8), 0);
    endtask

    task automatic t_reset_mid();
        mul8(7, 7, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(p8 == 8'd0, "R9", int'(p8), 0);
        check(ov8 == 1'b0, "R9", int'(ov8), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_sweep4();
        t_classes8();
        t_wrap8();
        t_valid8();
        t_hold8();
        t_random8();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule